// File: doc/BRIEF.md
# UART interrupt identification with transmit-empty holdoff

This block sits next to a UART that has receive and transmit FIFOs. It takes the status of the interrupt sources, ranks them by priority and presents a 4-bit identification code together with an interrupt request line. Line-status and modem-status sources are handled only as input flags here. The serial shifters live elsewhere.

Software reads the code through the identification read strobe. The transmit-empty source is the only one the block holds itself. After the transmit FIFO drains, that source waits for a programmable number of bit periods before it asserts. The wait is skipped when the FIFO has held two or more characters at once since the previous empty event. This gives the CPU time to refill the FIFO at start-up without taking a burst of transmit-empty interrupts. The code is registered, so a read acts on the value the host actually saw.

Top module: `uart_irq_ident`

## Requirements
- R1: With no source pending, the code is 4'b0001 and the request line is low; in every state the request line is the inverse of code bit 0.
- R2: Line status, when flagged, is reported as 4'b0110 and outranks all other sources.
- R3: Character timeout is reported as 4'b1100. It outranks receive-data-available, transmit-empty and modem.
- R4: Receive-data-available is reported as 4'b0100 while the trigger-level input is high, and is dropped as soon as that input falls. It outranks transmit-empty and modem.
- R5: Transmit-empty is reported as 4'b0010 and outranks modem status. Modem status (4'b0000) has the lowest priority.
- R6: When the transmit FIFO level reaches zero and it has not held two or more characters since the last empty event, transmit-empty becomes pending on the HOLD_TICKS-th bit tick after the empty level is registered. HOLD_TICKS = CHAR_BITS - STOP_BITS.
- R7: After reset with an empty transmit FIFO, the holdoff of R6 also applies.
- R8: When the FIFO level reaches zero after holding two or more characters, transmit-empty is pending at the next clock edge, with no ticks needed.
- R9: A transmit write, or a non-zero FIFO level, clears a pending transmit-empty and cancels a running holdoff.
- R10: An identification read clears transmit-empty only when the registered code at that read is 4'b0010.
- R11: The code is registered. It reflects the sources one clock edge after they change. A source that arrives in the same cycle as a read does not block that read from clearing transmit-empty.
- R12: Only the six codes listed above are ever produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_flag | input | 1 | Line-status source pending |
| rx_trig | input | 1 | Receive data available / trigger level reached |
| rx_timeout | input | 1 | Character timeout pending |
| modem_flag | input | 1 | Modem-status source pending |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| thr_wr | input | 1 | Transmit holding write strobe |
| id_rd | input | 1 | Identification read strobe |
| bit_tick | input | 1 | One pulse per serial bit period |
| irq_id | output | 4 | Identification code |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with TX_DEPTH = 4, CHAR_BITS = 10 and STOP_BITS = 1, which gives a 9-tick holdoff. With these values the bench can step through the whole holdoff window one tick at a time. It can also sweep every peak FIFO level from 1 to 4, which exercises both the delayed path (peak 1) and the immediate path (peak 2 and above).

The four source flags are swept over all 16 combinations, once with transmit-empty pending and once without it, so the full priority table is compared against a model computed in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    ID_MODEM   = 4'b0000,
    ID_NONE    = 4'b0001,
    ID_THRE    = 4'b0010,
    ID_RDA     = 4'b0100,
    ID_LINE    = 4'b0110,
    ID_TIMEOUT = 4'b1100
  } irq_id_e;
endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic    line_flag,
  input  logic    rx_timeout,
  input  logic    rx_trig,
  input  logic    thre_pend,
  input  logic    modem_flag,
  output irq_id_e code
);
  always_comb begin
    if (line_flag)       code = ID_LINE;
    else if (rx_timeout) code = ID_TIMEOUT;
    else if (rx_trig)    code = ID_RDA;
    else if (thre_pend)  code = ID_THRE;
    else if (modem_flag) code = ID_MODEM;
    else                 code = ID_NONE;
  end
endmodule

// File: rtl/uart_thre_holdoff.sv
module uart_thre_holdoff #(
  parameter int CNT_W      = 5,
  parameter int HOLD_TICKS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             thr_wr,
  input  logic             rd_hit,
  input  logic             bit_tick,
  output logic             thre_pend
);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_TICKS);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(1);

  logic              empty_q, empty_n;
  logic              multi_q, multi_n;
  logic              act_q, act_n;
  logic [HOLD_W-1:0] cnt_q, cnt_n;
  logic              pend_q, pend_n;
  logic              tx_empty, empty_rise, cnt_en;

  assign tx_empty   = (tx_level == '0);
  assign empty_rise = tx_empty && !empty_q;
  assign cnt_en     = act_q && bit_tick;

  always_comb begin
    empty_n = tx_empty;
    multi_n = multi_q;
    act_n   = act_q;
    cnt_n   = cnt_q;
    pend_n  = pend_q;
    if (tx_level >= CNT_W'(2)) multi_n = 1'b1;
    else if (empty_rise)       multi_n = 1'b0;
    if (empty_rise && !multi_q) begin
      act_n = 1'b1;
      cnt_n = HOLD_LOAD;
    end else if (act_q && (thr_wr || !tx_empty)) begin
      act_n = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == HOLD_LAST) act_n = 1'b0;
      else                    cnt_n = cnt_q - HOLD_W'(1);
    end
    if (thr_wr || rd_hit || !tx_empty)             pend_n = 1'b0;
    else if (empty_rise && multi_q)                pend_n = 1'b1;
    else if (cnt_en && cnt_q == HOLD_LAST)         pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      multi_q <= 1'b0;
      act_q   <= 1'b0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= empty_n;
      multi_q <= multi_n;
      act_q   <= act_n;
      if (act_n) cnt_q <= cnt_n;
      pend_q  <= pend_n;
    end
  end

  assign thre_pend = pend_q;

  assert_wr_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_pend);
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> !thre_pend);
  assert_set_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thre_pend) |-> $past(tx_level == '0));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int TX_DEPTH  = 16,
  parameter int CHAR_BITS = 10,
  parameter int STOP_BITS = 1,
  localparam int CNT_W    = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_flag,
  input  logic             rx_trig,
  input  logic             rx_timeout,
  input  logic             modem_flag,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             thr_wr,
  input  logic             id_rd,
  input  logic             bit_tick,
  output logic [3:0]       irq_id,
  output logic             irq
);
  localparam int HOLD_TICKS = CHAR_BITS - STOP_BITS;

  irq_id_e code_n, id_q;
  logic    thre_pend, rd_hit;

  assign rd_hit = id_rd && (id_q == ID_THRE);

  uart_thre_holdoff #(.CNT_W(CNT_W), .HOLD_TICKS(HOLD_TICKS)) holdoff_i (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .thr_wr(thr_wr),
    .rd_hit(rd_hit), .bit_tick(bit_tick), .thre_pend(thre_pend)
  );

  uart_irq_prio prio_i (
    .line_flag(line_flag), .rx_timeout(rx_timeout), .rx_trig(rx_trig),
    .thre_pend(thre_pend), .modem_flag(modem_flag), .code(code_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= ID_NONE;
    else        id_q <= code_n;
  end

  assign irq_id = id_q;
  assign irq    = ~id_q[0];

  assert_legal_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_id inside {4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b0110, 4'b1100});
  assert_line_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    line_flag |=> (irq_id == 4'b0110));
  assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_flag && !rx_timeout && !rx_trig && !thre_pend && !modem_flag)
      |=> (irq_id == 4'b0001 && !irq));
  assert_timeout_rank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_flag && rx_timeout) |=> (irq_id == 4'b1100));
endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
  localparam int DEPTH = 4;
  localparam int CBITS = 10;
  localparam int SBITS = 1;
  localparam int HOLD  = CBITS - SBITS;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_flag = 0, rx_trig = 0, rx_timeout = 0, modem_flag = 0;
  logic [CW-1:0] tx_level = '0;
  logic thr_wr = 0, id_rd = 0, bit_tick = 0;
  logic [3:0] irq_id;
  logic irq;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  uart_irq_ident #(.TX_DEPTH(DEPTH), .CHAR_BITS(CBITS), .STOP_BITS(SBITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_flag(line_flag), .rx_trig(rx_trig),
    .rx_timeout(rx_timeout), .modem_flag(modem_flag), .tx_level(tx_level),
    .thr_wr(thr_wr), .id_rd(id_rd), .bit_tick(bit_tick),
    .irq_id(irq_id), .irq(irq)
  );

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    step();
    bit_tick = 1'b0;
  endtask

  task automatic check(input logic [3:0] exp, input string req);
    checks++;
    if (irq_id !== exp || irq !== ~exp[0]) begin
      errors++;
      $display("FAIL %s: actual id=%b irq=%b expected id=%b irq=%b",
               req, irq_id, irq, exp, ~exp[0]);
    end
  endtask

  function automatic logic [3:0] model(input logic ls, input logic to,
                                       input logic rda, input logic th,
                                       input logic md);
    if (ls)      return 4'b0110;
    else if (to) return 4'b1100;
    else if (rda) return 4'b0100;
    else if (th) return 4'b0010;
    else if (md) return 4'b0000;
    else         return 4'b0001;
  endfunction

  task automatic sweep(input logic th, input string req);
    for (int v = 0; v < 16; v++) begin
      {line_flag, rx_timeout, rx_trig, modem_flag} = v[3:0];
      step();
      check(model(v[3], v[2], v[1], th, v[0]), req);
    end
    {line_flag, rx_timeout, rx_trig, modem_flag} = 4'b0;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    check(4'b0001, "R1 reset");
    // R7: start-up holdoff with empty FIFO
    for (int k = 1; k < HOLD; k++) begin
      tick();
      check(4'b0001, "R7 startup wait");
    end
    tick();
    check(4'b0001, "R11 latency");
    step();
    check(4'b0010, "R7 startup expire");

    // R9: write clears pending
    thr_wr = 1'b1; tx_level = CW'(1);
    step();
    thr_wr = 1'b0;
    step();
    check(4'b0001, "R9 write clear");

    // R5/R2/R3/R4 sweep without transmit-empty
    sweep(1'b0, "R2 R3 R4 R5 sweep no thre");

    // R8: peak two gives immediate interrupt, then sweep with it pending
    tx_level = CW'(2); step();
    tx_level = '0; step();
    step();
    check(4'b0010, "R8 immediate");
    sweep(1'b1, "R2 R3 R4 R5 sweep thre");

    // R10: read while higher source is shown does not clear
    rx_trig = 1'b1; step();
    check(4'b0100, "R4 rda shown");
    id_rd = 1'b1; step(); id_rd = 1'b0;
    rx_trig = 1'b0; step();
    check(4'b0010, "R10 read under rda keeps");
    // R11: source arriving with the read does not block clearing
    rx_trig = 1'b1; id_rd = 1'b1; step();
    id_rd = 1'b0; rx_trig = 1'b0;
    check(4'b0100, "R11 race rda");
    step();
    check(4'b0001, "R11 race cleared");

    // R9: holdoff cancelled by a write
    tx_level = CW'(1); step();
    tx_level = '0; step();
    repeat (4) tick();
    thr_wr = 1'b1; tx_level = CW'(1); step(); thr_wr = 1'b0;
    repeat (HOLD + 2) tick();
    check(4'b0001, "R9 holdoff cancel");

    // R6/R8 sweep over peak level
    for (int p = 1; p <= DEPTH; p++) begin
      tx_level = CW'(p); step();
      tx_level = '0; step();
      if (p >= 2) begin
        step();
        check(4'b0010, "R8 peak immediate");
      end else begin
        for (int k = 1; k < HOLD; k++) begin
          tick();
          check(4'b0001, "R6 holdoff wait");
        end
        tick(); step();
        check(4'b0010, "R6 holdoff expire");
      end
      if (p % 2 == 1) begin
        id_rd = 1'b1; step(); id_rd = 1'b0;
        step();
        check(4'b0001, "R10 read clears");
      end else begin
        thr_wr = 1'b1; step(); thr_wr = 1'b0;
        step();
        check(4'b0001, "R9 write clears");
      end
    end
    finish_run();
  end
endmodule